// File: doc/BRIEF.md
# LCD Row-Scan Timing Generator

This block sequences the row scan of a dot-matrix LCD. It runs on the display clock. On each clock step it selects one common (row) line and presents that row number on a read address to the display memory. It takes back the matching segment row and registers a single output word that holds every common and segment drive bit for that step. The word feeds the high-voltage output stage.

The scan length follows the selected multiplex duty. A low-power icon mode parks the scan on the last common line. Either side of the panel can be mirrored to match the panel layout.

The block also keeps a frame polarity bit, which flips at the end of each frame so the level selector can alternate the drive and give AC drive. A strobe marks each clock in which the output word carries a live scan step. When the display is switched off, the word is blanked and the scan position is frozen.

Top module: `lcd_scan_timer`

## Requirements
- R1: After reset: the output word is all zero, `frame_pol` is 0, `line_strobe` is 0 and `mem_rd_row` is 0.
- R2: `duty_sel` encodes the scan length: 0 means 16 rows, 1 means 32 rows, and 2 or 3 mean all NUM_COM rows. While the display is on and icon mode is off, the row counter advances by one per clock from 0 to length−1 and then returns to 0. `mem_rd_row` shows the row counter.
- R3: Word bits 0 to NUM_COM−1 are the common field. After each clock edge at which the display was on, exactly one common bit is set. It sits at the scanned row r, or at NUM_COM−1−r when `com_flip` is 1.
- R4: Word bit NUM_COM+c holds segment c. It takes bit c of the memory row read for the scanned row, or bit NUM_SEG−1−c when `seg_flip` is 1.
- R5: The memory read is combinational: `mem_rd_data` must hold the row addressed by `mem_rd_row` in the same cycle, and the word captures it at the next edge.
- R6: `frame_pol` inverts at every clock edge that ends a frame, and holds at every other edge.
- R7: In icon mode with the display on, the scanned row is NUM_COM−1, so `mem_rd_row` reads NUM_COM−1. Every step is a frame end, so `frame_pol` inverts at each edge.
- R8: While the display is off, the word loads all zeros at each edge, and the row counter and `frame_pol` hold their values.
- R9: `line_strobe` equals the value `disp_on` had at the previous clock edge.
- R10: In scan mode, a row counter at or beyond length−1 ends the frame and returns to 0 on the next step. This applies after leaving icon mode and after shortening the duty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Display clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| duty_sel | input | 2 | Multiplex duty select |
| com_flip | input | 1 | Mirror the common field |
| seg_flip | input | 1 | Mirror the segment field |
| disp_on | input | 1 | Display enable |
| icon_mode | input | 1 | Low-power scan of the last common only |
| mem_rd_row | output | ROW_W | Display memory row address |
| mem_rd_data | input | NUM_SEG | Segment bits of the addressed row |
| latch_word | output | NUM_COM+NUM_SEG | Common field (low bits) and segment field (high bits) |
| frame_pol | output | 1 | Frame polarity for the level selector |
| line_strobe | output | 1 | Output word holds a live scan step |

## Verification
The bench builds the block with NUM_COM kept at 33 and NUM_SEG reduced to 8. This keeps the true 16, 32 and 33 duty lengths and the icon row at 32. It also makes a full word of 41 bits fit in one compare.

At this size, every duty setting can be run through twice per setting, for all four mirror combinations. Each row's memory data is a distinct computed byte, so a wrong or late row, or a reversed segment order, shows in the word.

The reduced build also allows directed runs that leave icon mode with row 32 in a 16-row duty, cut the duty in the middle of a frame, and hold the display off.

// File: rtl/lcd_scan_pkg.sv
package lcd_scan_pkg;

  typedef enum logic [1:0] {
    DUTY_SHORT = 2'd0,
    DUTY_MID   = 2'd1,
    DUTY_FULL  = 2'd2,
    DUTY_FULLB = 2'd3
  } duty_e;

  // Rows scanned per frame for a duty code.
  function automatic int unsigned duty_rows(input logic [1:0] sel, input int unsigned n_com);
    case (duty_e'(sel))
      DUTY_SHORT: return (n_com - 1) / 2;
      DUTY_MID:   return n_com - 1;
      default:    return n_com;
    endcase
  endfunction

  // Mirrored position within a field of n entries.
  function automatic int unsigned mirror_idx(input int unsigned idx, input int unsigned n);
    return n - 1 - idx;
  endfunction

endpackage

// File: rtl/lcd_row_sequencer.sv
module lcd_row_sequencer
  import lcd_scan_pkg::*;
#(
  parameter int unsigned NUM_COM = 33,
  parameter int unsigned ROW_W   = $clog2(NUM_COM)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       duty_sel,
  input  logic             disp_on,
  input  logic             icon_mode,
  output logic [ROW_W-1:0] scan_row,
  output logic             frame_pol,
  output logic             line_strobe,
  output logic             frame_end
);

  localparam logic [ROW_W-1:0] ICON_ROW = ROW_W'(NUM_COM - 1);

  logic [ROW_W-1:0] row_q;
  logic [ROW_W-1:0] last_row;
  logic             at_last;

  assign last_row  = ROW_W'(duty_rows(duty_sel, NUM_COM) - 1);
  assign at_last   = (row_q >= last_row);
  assign scan_row  = icon_mode ? ICON_ROW : row_q;
  assign frame_end = disp_on && (icon_mode || at_last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q       <= '0;
      frame_pol   <= 1'b0;
      line_strobe <= 1'b0;
    end else begin
      line_strobe <= disp_on;
      if (disp_on) begin
        if (icon_mode)    row_q <= ICON_ROW;
        else if (at_last) row_q <= '0;
        else              row_q <= row_q + 1'b1;
      end
      if (frame_end) frame_pol <= ~frame_pol;
    end
  end

  p_row_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    row_q <= ICON_ROW);

  p_pol_flip_r6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> (frame_pol != $past(frame_pol)));

  p_pol_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_end |=> $stable(frame_pol));

  p_row_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !disp_on |=> $stable(row_q));

  p_wrap_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_on && !icon_mode && at_last) |=> (row_q == '0));

endmodule

// File: rtl/lcd_latch_builder.sv
module lcd_latch_builder
  import lcd_scan_pkg::*;
#(
  parameter int unsigned NUM_COM = 33,
  parameter int unsigned NUM_SEG = 120,
  parameter int unsigned ROW_W   = $clog2(NUM_COM)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       disp_on,
  input  logic                       com_flip,
  input  logic                       seg_flip,
  input  logic [ROW_W-1:0]           scan_row,
  input  logic [NUM_SEG-1:0]         mem_rd_data,
  output logic [NUM_COM+NUM_SEG-1:0] latch_word
);

  logic [NUM_COM-1:0] com_vec;
  logic [NUM_SEG-1:0] seg_vec;

  for (genvar k = 0; k < NUM_COM; k++) begin : g_com
    assign com_vec[k] = com_flip ? (scan_row == ROW_W'(mirror_idx(k, NUM_COM)))
                                 : (scan_row == ROW_W'(k));
  end

  for (genvar c = 0; c < NUM_SEG; c++) begin : g_seg
    assign seg_vec[c] = seg_flip ? mem_rd_data[NUM_SEG-1-c] : mem_rd_data[c];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       latch_word <= '0;
    else if (disp_on) latch_word <= {seg_vec, com_vec};
    else              latch_word <= '0;
  end

  p_com_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(latch_word[NUM_COM-1:0]));

  p_com_live_r3: assert property (@(posedge clk) disable iff (!rst_n)
    disp_on |=> ($countones(latch_word[NUM_COM-1:0]) == 1));

endmodule

// File: rtl/lcd_scan_timer.sv
module lcd_scan_timer
  import lcd_scan_pkg::*;
#(
  parameter int unsigned NUM_COM = 33,
  parameter int unsigned NUM_SEG = 120,
  parameter int unsigned ROW_W   = $clog2(NUM_COM)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [1:0]                 duty_sel,
  input  logic                       com_flip,
  input  logic                       seg_flip,
  input  logic                       disp_on,
  input  logic                       icon_mode,
  output logic [ROW_W-1:0]           mem_rd_row,
  input  logic [NUM_SEG-1:0]         mem_rd_data,
  output logic [NUM_COM+NUM_SEG-1:0] latch_word,
  output logic                       frame_pol,
  output logic                       line_strobe
);

  logic [ROW_W-1:0] scan_row;
  logic             frame_end;

  lcd_row_sequencer #(.NUM_COM(NUM_COM), .ROW_W(ROW_W)) i_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .duty_sel    (duty_sel),
    .disp_on     (disp_on),
    .icon_mode   (icon_mode),
    .scan_row    (scan_row),
    .frame_pol   (frame_pol),
    .line_strobe (line_strobe),
    .frame_end   (frame_end)
  );

  assign mem_rd_row = scan_row;

  lcd_latch_builder #(.NUM_COM(NUM_COM), .NUM_SEG(NUM_SEG), .ROW_W(ROW_W)) i_latch (
    .clk         (clk),
    .rst_n       (rst_n),
    .disp_on     (disp_on),
    .com_flip    (com_flip),
    .seg_flip    (seg_flip),
    .scan_row    (scan_row),
    .mem_rd_data (mem_rd_data),
    .latch_word  (latch_word)
  );

  p_blank_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !line_strobe |-> (latch_word == '0));

  p_icon_line_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_on && icon_mode && !com_flip) |=> latch_word[NUM_COM-1]);

  p_icon_frame_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_on && icon_mode) |-> frame_end);

endmodule

// File: tb/test_lcd_scan_timer.sv
`timescale 1ns/1ps
module test_lcd_scan_timer;

  localparam int NC = 33;
  localparam int NS = 8;
  localparam int RW = $clog2(NC);
  localparam int LW = NC + NS;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    duty_sel = 2'd0;
  logic          com_flip = 1'b0, seg_flip = 1'b0, disp_on = 1'b0, icon_mode = 1'b0;
  logic [RW-1:0] mem_rd_row;
  logic [NS-1:0] mem_rd_data;
  logic [LW-1:0] latch_word;
  logic          frame_pol, line_strobe;

  int n_chk = 0, n_bad = 0;
  int e_row = 0, e_pol = 0, e_strobe = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  function automatic logic [NS-1:0] pat(input int r);
    return NS'((r * 29 + 5) ^ (r << 3));
  endfunction

  always_comb mem_rd_data = pat(int'(mem_rd_row));

  lcd_scan_timer #(.NUM_COM(NC), .NUM_SEG(NS)) i_lcd_scan_timer (
    .clk(clk), .rst_n(rst_n), .duty_sel(duty_sel), .com_flip(com_flip),
    .seg_flip(seg_flip), .disp_on(disp_on), .icon_mode(icon_mode),
    .mem_rd_row(mem_rd_row), .mem_rd_data(mem_rd_data), .latch_word(latch_word),
    .frame_pol(frame_pol), .line_strobe(line_strobe)
  );

  task automatic chk(input string req, input string ph, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s (%s) %s: actual %0h expected %0h", req, ph, what, act, exp);
    end
  endtask

  task automatic step(input string ph);
    int cur, len, sh;
    logic [NS-1:0] d;
    logic [NC-1:0] e_com;
    logic [NS-1:0] e_seg;
    cur = icon_mode ? NC - 1 : e_row;
    len = (duty_sel == 2'd0) ? 16 : (duty_sel == 2'd1) ? 32 : 33;
    e_com = '0;
    e_seg = '0;
    d = pat(cur);
    if (disp_on) begin
      sh = com_flip ? (NC - 1) - cur : cur;
      e_com = NC'(1) << sh;
      for (int c = 0; c < NS; c++) e_seg[c] = seg_flip ? d[NS - 1 - c] : d[c];
      if (icon_mode || e_row >= len - 1) e_pol = 1 - e_pol;
      if (icon_mode) e_row = NC - 1;
      else if (e_row >= len - 1) e_row = 0;
      else e_row = e_row + 1;
    end
    e_strobe = disp_on;
    @(posedge clk);
    @(negedge clk);
    chk("R3", ph, "common field", 64'(latch_word[NC-1:0]), 64'(e_com));
    chk("R4", ph, "segment field", 64'(latch_word[LW-1:NC]), 64'(e_seg));
    chk("R6", ph, "frame_pol", 64'(frame_pol), 64'(e_pol));
    chk("R9", ph, "line_strobe", 64'(line_strobe), 64'(e_strobe));
    chk("R2", ph, "mem_rd_row", 64'(mem_rd_row), 64'(icon_mode ? NC - 1 : e_row));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "reset", "word", 64'(latch_word), 64'd0);
    chk("R1", "reset", "frame_pol", 64'(frame_pol), 64'd0);
    chk("R1", "reset", "strobe", 64'(line_strobe), 64'd0);
    chk("R1", "reset", "mem_rd_row", 64'(mem_rd_row), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "idle", "word", 64'(latch_word), 64'd0);

    // R2 / R3 / R4 / R5: every duty code with every mirror setting
    disp_on = 1'b1;
    for (int du = 0; du < 4; du++) begin
      for (int f = 0; f < 4; f++) begin
        duty_sel = 2'(du);
        com_flip = f[0];
        seg_flip = f[1];
        for (int s = 0; s < 2 * 33 + 1; s++) step("R2 sweep");
      end
    end

    // R8: display off freezes the scan and blanks the word
    disp_on = 1'b0;
    for (int s = 0; s < 5; s++) step("R8 off");
    disp_on = 1'b1;
    for (int s = 0; s < 3; s++) step("R8 resume");

    // R7: icon mode, then R10: leave it in the short duty
    duty_sel = 2'd0;
    com_flip = 1'b0;
    icon_mode = 1'b1;
    for (int s = 0; s < 6; s++) step("R7 icon");
    com_flip = 1'b1;
    for (int s = 0; s < 3; s++) step("R7 icon flip");
    icon_mode = 1'b0;
    com_flip = 1'b0;
    for (int s = 0; s < 4; s++) step("R10 exit icon");

    // R10: shorten the duty mid-frame
    duty_sel = 2'd2;
    for (int s = 0; s < 25; s++) step("R10 long");
    duty_sel = 2'd0;
    for (int s = 0; s < 20; s++) step("R10 cut");

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual running expected done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

endmodule